// File: doc/BRIEF.md
# SPI Flash Dummy-Cycle Injector

This block sits in a flash controller between the host's direct-command write path and a byte-wide SPI shift engine. During each chip-select frame it watches the bytes the host pushes out. It decodes the first byte as the command opcode, looks up how many dummy bytes that command needs, and counts the address bytes that follow. When the frame reaches the dummy phase, the block produces the dummy bytes itself, using a programmable fill value. The host write that lands on that phase is consumed and not sent on. The host therefore never has to clock out dummy bytes by hand, and the controller does not have to know the command set.

Host writes carry 1 to 4 bytes, and those bytes leave least significant byte first. Forwarded bytes and generated fill bytes share one valid/ready output stream. Back-pressure follows the usual rule: while `out_valid` is high and `out_ready` is low, the byte on `out_data` is held unchanged. The host side is also valid/ready. `host_ready` is high only when the output holds no unsent bytes, so a write is taken whole or not at all. A write is taken on any rising clock edge where both `host_valid` and `host_ready` are high. The fill value sits in an 8-bit register reached through a simple register port whose read data is combinational.

Top module: `spi_dummy_snoop`

## Requirements
- R1: After reset, `out_valid` is 0, `host_ready` is 1 and the fill register reads 0x00. Snooping is off, so writes made before any chip-select assertion pass through unchanged.
- R2: An accepted write of size N (1..4) produces exactly N output bytes, in the order `host_data[7:0]`, then `[15:8]`, then `[23:16]`, then `[31:24]`. `out_valid` rises in the cycle after acceptance.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays stable. `host_ready` stays low while any output byte is still pending.
- R4: When chip select goes active, the next write's low byte is decoded as the opcode. Opcodes 0x03, 0x13, 0x02, 0x12, 0xA2, 0x32 and 0x34 need no dummies. Every opcode not listed in R5 is unknown. For both of these cases, every write in the frame passes through unchanged.
- R5: Opcodes 0x0B, 0x3B, 0x6B, 0x3C and 0x6C need 1 dummy unit. Opcodes 0xBB, 0x0C and 0xBC need 2. Opcodes 0xEB and 0xEC need 4. At the dummy phase the block emits 8 fill bytes per unit, all equal to the fill register, and then emits nothing from the write that triggered them.
- R6: After the opcode, each forwarded write advances a byte position by its size. The opcode counts as position 0 and its write's size is added. The dummy phase is the first write taken once the position is at least AW+1, where AW is 4 when `addr4_mode`=1 and 3 otherwise.
- R7: After the fill bytes, snooping stays off for the rest of the frame, and later writes pass through unchanged.
- R8: A register write at offset 0x54 stores only `reg_wdata[7:0]`. A read at 0x54 returns that byte zero-extended to 32 bits.
- R9: A read at any other offset returns 0xFFFFFFFF.
- R10: Dropping chip select while fill bytes remain aborts them. `out_valid` falls and `host_ready` rises in the following cycle. Nothing carries over into the next frame, which decodes a fresh opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_active | input | 1 | Chip select active (frame open); raise it at least one cycle before the opcode write |
| addr4_mode | input | 1 | 1: 4-byte addresses, 0: 3-byte addresses |
| host_valid | input | 1 | Host write valid |
| host_ready | output | 1 | Host write accepted when high with `host_valid` |
| host_data | input | 32 | Host write bytes, least significant first |
| host_size | input | 3 | Number of bytes in the write, 1..4 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Shift engine ready for a byte |
| out_data | output | 8 | Output byte |

## Verification
Two situations are hard to reach from the ports. The first is a write that splits the address boundary. In 4-byte mode, an opcode sent together with three address bytes in one write leaves the position at 4, which is still one short of the dummy phase, so the next single byte must be forwarded and the write after it dropped. The bench reaches this case by sweeping all 256 opcodes in both address modes, with two write-grouping patterns, under a periodically stalling output. The second is an abort in the middle of the fill. To get there, the bench holds `out_ready` low just after the triggering write is taken and then drops chip select.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  localparam int          IDX_W     = 8;
  localparam logic [7:0]  IDX_OFF   = 8'hFF;
  localparam logic [7:0]  IDX_START = 8'h00;
  localparam int          MAX_UNITS = 4;
  localparam int          UNIT_BYTES = 8;

  typedef enum logic [1:0] {EM_IDLE, EM_HOST, EM_FILL} em_state_t;
endpackage

// File: rtl/snoop_opcode_lut.sv
module snoop_opcode_lut (
  input  logic [7:0] opcode,
  output logic       known,
  output logic [2:0] units
);
  always_comb begin
    known = 1'b1;
    units = 3'd0;
    case (opcode)
      8'h03, 8'h13, 8'h02, 8'h12, 8'hA2, 8'h32, 8'h34: units = 3'd0;
      8'h0B, 8'h3B, 8'h6B, 8'h3C, 8'h6C:               units = 3'd1;
      8'hBB, 8'h0C, 8'hBC:                             units = 3'd2;
      8'hEB, 8'hEC:                                    units = 3'd4;
      default: known = 1'b0;
    endcase
  end
endmodule

// File: rtl/snoop_tracker.sv
module snoop_tracker import snoop_pkg::*; #(
  parameter int SIZE_W = 3,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active,
  input  logic              addr4_mode,
  input  logic              acc,
  input  logic [7:0]        acc_low,
  input  logic [SIZE_W-1:0] acc_size,
  output logic              drop,
  output logic [CNT_W-1:0]  pending
);
  logic [IDX_W-1:0] idx;
  logic             cs_q;
  logic             known;
  logic [2:0]       units;
  logic [IDX_W-1:0] dummy_pos;
  logic             at_dummy;

  snoop_opcode_lut u_lut (.opcode(acc_low), .known(known), .units(units));

  assign dummy_pos = addr4_mode ? IDX_W'(5) : IDX_W'(4);
  assign at_dummy  = cs_active && cs_q && (idx != IDX_OFF) && (idx >= dummy_pos);
  assign drop      = at_dummy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx     <= IDX_OFF;
      pending <= '0;
      cs_q    <= 1'b0;
    end else begin
      cs_q <= cs_active;
      if (!cs_active) begin
        idx     <= IDX_OFF;
        pending <= '0;
      end else if (!cs_q) begin
        idx     <= IDX_START;
        pending <= '0;
      end else if (acc) begin
        if (idx == IDX_OFF) begin
          idx <= IDX_OFF;
        end else if (idx == IDX_START) begin
          if (!known || units == 3'd0) begin
            idx <= IDX_OFF;
          end else begin
            pending <= CNT_W'(units) << $clog2(UNIT_BYTES);
            idx     <= idx + IDX_W'(acc_size);
          end
        end else if (at_dummy) begin
          idx     <= IDX_OFF;
          pending <= '0;
        end else begin
          idx <= idx + IDX_W'(acc_size);
        end
      end
    end
  end
endmodule

// File: rtl/snoop_emitter.sv
module snoop_emitter import snoop_pkg::*; #(
  parameter int HOST_BYTES = 4,
  parameter int SIZE_W     = 3,
  parameter int CNT_W      = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_active,
  input  logic                    load_host,
  input  logic                    load_fill,
  input  logic [8*HOST_BYTES-1:0] host_word,
  input  logic [SIZE_W-1:0]       host_size,
  input  logic [CNT_W-1:0]        fill_count,
  input  logic [7:0]              fill_byte,
  input  logic                    out_ready,
  output logic                    idle,
  output logic                    fill_busy,
  output logic                    out_valid,
  output logic [7:0]              out_data
);
  em_state_t               state;
  logic [8*HOST_BYTES-1:0] shreg;
  logic [CNT_W-1:0]        rem;

  assign idle      = (state == EM_IDLE);
  assign fill_busy = (state == EM_FILL);
  assign out_valid = !idle;
  assign out_data  = fill_busy ? fill_byte : shreg[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= EM_IDLE;
      shreg <= '0;
      rem   <= '0;
    end else begin
      case (state)
        EM_IDLE: begin
          if (load_fill) begin
            state <= EM_FILL;
            rem   <= fill_count;
          end else if (load_host) begin
            state <= EM_HOST;
            shreg <= host_word;
            rem   <= CNT_W'(host_size);
          end
        end
        EM_HOST: begin
          if (out_ready) begin
            shreg <= shreg >> 8;
            rem   <= rem - CNT_W'(1);
            if (rem == CNT_W'(1)) state <= EM_IDLE;
          end
        end
        EM_FILL: begin
          if (!cs_active) begin
            state <= EM_IDLE;
            rem   <= '0;
          end else if (out_ready) begin
            rem <= rem - CNT_W'(1);
            if (rem == CNT_W'(1)) state <= EM_IDLE;
          end
        end
        default: state <= EM_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_dummy_snoop.sv
module spi_dummy_snoop import snoop_pkg::*; #(
  parameter int         HOST_BYTES = 4,
  parameter int         REG_AW     = 8,
  parameter int         REG_DW     = 32,
  parameter logic [7:0] FILL_OFF   = 8'h54
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cs_active,
  input  logic                              addr4_mode,
  input  logic                              host_valid,
  output logic                              host_ready,
  input  logic [8*HOST_BYTES-1:0]           host_data,
  input  logic [$clog2(HOST_BYTES+1)-1:0]   host_size,
  input  logic                              reg_wr,
  input  logic [REG_AW-1:0]                 reg_addr,
  input  logic [REG_DW-1:0]                 reg_wdata,
  output logic [REG_DW-1:0]                 reg_rdata,
  output logic                              out_valid,
  input  logic                              out_ready,
  output logic [7:0]                        out_data
);
  localparam int SIZE_W = $clog2(HOST_BYTES + 1);
  localparam int CNT_W  = $clog2(MAX_UNITS * UNIT_BYTES + 1);

  logic             accept;
  logic             drop;
  logic [CNT_W-1:0] pending;
  logic             em_idle;
  logic             fill_busy;
  logic [7:0]       fill_q;
  logic             unused_hi;

  assign host_ready = em_idle;
  assign accept     = host_valid && host_ready;
  assign unused_hi  = ^reg_wdata[REG_DW-1:8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  fill_q <= 8'h00;
    else if (reg_wr && reg_addr == REG_AW'(FILL_OFF)) fill_q <= reg_wdata[7:0];
  end

  assign reg_rdata = (reg_addr == REG_AW'(FILL_OFF)) ? REG_DW'(fill_q) : '1;

  snoop_tracker #(.SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .addr4_mode(addr4_mode),
    .acc(accept), .acc_low(host_data[7:0]), .acc_size(host_size),
    .drop(drop), .pending(pending)
  );

  snoop_emitter #(.HOST_BYTES(HOST_BYTES), .SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_emit (
    .clk(clk), .rst_n(rst_n), .cs_active(cs_active),
    .load_host(accept && !drop), .load_fill(accept && drop),
    .host_word(host_data), .host_size(host_size),
    .fill_count(pending), .fill_byte(fill_q), .out_ready(out_ready),
    .idle(em_idle), .fill_busy(fill_busy),
    .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/snoop_checker.sv
module snoop_checker #(
  parameter int         REG_AW   = 8,
  parameter int         REG_DW   = 32,
  parameter int         CNT_W    = 6,
  parameter logic [7:0] FILL_OFF = 8'h54
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_active,
  input logic              host_valid,
  input logic              host_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_data,
  input logic              fill_busy,
  input logic [7:0]        fill_byte,
  input logic [CNT_W-1:0]  pending,
  input logic [REG_AW-1:0] reg_addr,
  input logic [REG_DW-1:0] reg_rdata
);
  AST_ACCEPT_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid && host_ready |=> out_valid); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && cs_active |=> out_valid && $stable(out_data)); // R3
  AST_FILL_BLOCKS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    fill_busy |-> !host_ready && out_valid && out_data == fill_byte); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pending <= CNT_W'(32)); // R5
  AST_ABORT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    fill_busy && !cs_active |=> !fill_busy && host_ready); // R10
  AST_FILL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == REG_AW'(FILL_OFF) |-> reg_rdata[REG_DW-1:8] == '0); // R8
  AST_UNIMPL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr != REG_AW'(FILL_OFF) |-> reg_rdata == '1); // R9
endmodule

bind spi_dummy_snoop snoop_checker #(
  .REG_AW(REG_AW), .REG_DW(REG_DW), .CNT_W(CNT_W), .FILL_OFF(FILL_OFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_active(cs_active),
  .host_valid(host_valid), .host_ready(host_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .fill_busy(fill_busy), .fill_byte(fill_q), .pending(pending),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/spi_dummy_snoop_tb.sv
module spi_dummy_snoop_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_active = 1'b0;
  logic        addr4_mode = 1'b0;
  logic        host_valid = 1'b0;
  logic        host_ready;
  logic [31:0] host_data = '0;
  logic [2:0]  host_size = 3'd1;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int ready_mode = 1;
  logic [7:0] got[$];
  logic [7:0] exp[$];

  always #2 clk = ~clk;

  spi_dummy_snoop u_dut (
    .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .addr4_mode(addr4_mode),
    .host_valid(host_valid), .host_ready(host_ready), .host_data(host_data),
    .host_size(host_size), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  always @(negedge clk) begin
    cyc++;
    case (ready_mode)
      0: out_ready = 1'b0;
      1: out_ready = 1'b1;
      default: out_ready = (cyc % 4) != 3;
    endcase
    if (out_valid && out_ready) got.push_back(out_data);
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic int units_of(input logic [7:0] op);
    case (op)
      8'h0B, 8'h3B, 8'h6B, 8'h3C, 8'h6C: return 1;
      8'hBB, 8'h0C, 8'hBC:               return 2;
      8'hEB, 8'hEC:                      return 4;
      default:                           return 0;
    endcase
  endfunction

  task automatic hwrite(input logic [31:0] d, input int sz);
    @(negedge clk);
    host_valid = 1'b1; host_data = d; host_size = 3'(sz);
    while (!host_ready) @(negedge clk);
    @(negedge clk);
    host_valid = 1'b0;
  endtask

  task automatic rwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rcheck(input logic [7:0] a, input logic [31:0] e, input string req);
    @(negedge clk);
    reg_addr = a;
    #1 check(reg_rdata === e, req, reg_rdata, e);
  endtask

  task automatic drain();
    @(negedge clk);
    while (!(host_ready && !out_valid)) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic compare(input string req);
    bit ok = (got.size() == exp.size());
    int first = -1;
    if (ok) foreach (exp[i]) if (got[i] !== exp[i] && first < 0) first = i;
    if (!ok) check(0, req, got.size(), exp.size());
    else if (first >= 0) check(0, req, got[first], exp[first]);
    else check(1, req, 0, 0);
  endtask

  task automatic push_fill(input int n, input logic [7:0] f);
    for (int k = 0; k < 8 * n; k++) exp.push_back(f);
  endtask

  // variant 0: opcode alone, then all address bytes in one write, then D, then T
  // variant 1: opcode+3 address bytes in one write, then E, then D, then T
  task automatic run_frame(input logic [7:0] op, input bit a4, input int variant);
    logic [7:0] f = op ^ 8'h5A;
    int n = units_of(op);
    int aw = a4 ? 4 : 3;
    string req;
    rwrite(8'h54, {24'hABCDEF, f});
    addr4_mode = a4;
    @(negedge clk); cs_active = 1'b1;
    @(negedge clk);
    got.delete(); exp.delete();
    if (variant == 0) begin
      hwrite({24'h0, op}, 1);
      hwrite(32'h44332211, aw);
      hwrite(32'hD0, 1);
      hwrite(32'h7E, 1);
      exp.push_back(op);
      for (int k = 0; k < aw; k++) exp.push_back(8'(8'h11 * (k + 1)));
      if (n > 0) push_fill(n, f); else exp.push_back(8'hD0);
      exp.push_back(8'h7E); // R7 trailing write passes after fill
      req = (n == 0) ? "R4" : "R5";
    end else begin
      hwrite({24'h332211, op}, 4);
      hwrite(32'hE1, 1);
      hwrite(32'hD0, 1);
      hwrite(32'h7E, 1);
      exp.push_back(op); exp.push_back(8'h11); exp.push_back(8'h22); exp.push_back(8'h33);
      if (n == 0) begin
        exp.push_back(8'hE1); exp.push_back(8'hD0);
      end else if (!a4) begin
        push_fill(n, f); exp.push_back(8'hD0);
      end else begin
        exp.push_back(8'hE1); push_fill(n, f);
      end
      exp.push_back(8'h7E);
      req = (n == 0) ? "R4" : "R6";
    end
    drain();
    cs_active = 1'b0;
    compare(req);
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] hold;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(out_valid === 1'b0, "R1", out_valid, 0);
    check(host_ready === 1'b1, "R1", host_ready, 1);
    rcheck(8'h54, 32'h0, "R1");
    // R1 snooping off before any frame
    got.delete(); exp.delete();
    hwrite(32'h0B, 1); hwrite(32'h99, 1); hwrite(32'h55, 1); hwrite(32'h66, 1); hwrite(32'h77, 1);
    drain();
    exp = '{8'h0B, 8'h99, 8'h55, 8'h66, 8'h77};
    compare("R1");
    // R2 byte order for all sizes
    ready_mode = 2;
    for (int s = 1; s <= 4; s++) begin
      got.delete(); exp.delete();
      hwrite(32'hA4B3C2D1, s);
      drain();
      for (int k = 0; k < s; k++) exp.push_back(8'(32'hA4B3C2D1 >> (8 * k)));
      compare("R2");
    end
    // R3 stall holds data and blocks host
    ready_mode = 0;
    got.delete();
    @(negedge clk);
    host_valid = 1'b1; host_data = 32'h0000BEEF; host_size = 3'd2;
    @(negedge clk);
    host_valid = 1'b0;
    hold = out_data;
    repeat (5) @(negedge clk);
    check(out_valid === 1'b1 && out_data === hold && hold === 8'hEF, "R3", out_data, 8'hEF);
    check(host_ready === 1'b0, "R3", host_ready, 0);
    ready_mode = 1;
    drain();
    exp = '{8'hEF, 8'hBE};
    compare("R3");
    // R8 / R9 register port
    rwrite(8'h54, 32'hABCD12A5);
    rcheck(8'h54, 32'h000000A5, "R8");
    rwrite(8'h50, 32'h00000011);
    rcheck(8'h54, 32'h000000A5, "R8");
    rcheck(8'h50, 32'hFFFFFFFF, "R9");
    rcheck(8'h00, 32'hFFFFFFFF, "R9");
    rcheck(8'hFC, 32'hFFFFFFFF, "R9");
    // R10 abort in the middle of fill
    rwrite(8'h54, 32'h3C);
    addr4_mode = 1'b0;
    @(negedge clk); cs_active = 1'b1;
    @(negedge clk);
    got.delete();
    hwrite(32'hEB, 1);
    hwrite(32'h332211, 3);
    drain();
    ready_mode = 0;
    hwrite(32'hD0, 1);
    repeat (3) @(negedge clk);
    check(out_valid === 1'b1 && out_data === 8'h3C, "R10", out_data, 8'h3C);
    cs_active = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(out_valid === 1'b0, "R10", out_valid, 0);
    check(host_ready === 1'b1, "R10", host_ready, 1);
    exp = '{8'hEB, 8'h11, 8'h22, 8'h33};
    compare("R10");
    ready_mode = 1;
    run_frame(8'h0B, 1'b0, 0); // R10 fresh frame after abort
    // sweep all opcodes, both address widths, two groupings (R4 R5 R6 R7)
    ready_mode = 2;
    for (int op = 0; op < 256; op++)
      for (int a = 0; a < 2; a++)
        for (int v = 0; v < 2; v++)
          run_frame(8'(op), a[0], v);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule